// File: doc/BRIEF.md
# Half-Duplex Serial Panel Register Port

This block is a three-wire serial master that reads and writes the 8-bit registers of a display panel. The three wires are an active-low frame enable, a serial clock, and one data line that both ends share. A request on the parallel side starts one 16-bit frame, and the block then runs the serial side by itself. During a write frame the master drives every bit: first the register address, then the value.

A read frame starts the same way. The master sends the address with a read marker in its top bit. After the eighth clock it releases the data line and shifts in the panel's 8-bit reply, which appears on the parallel side when the frame ends. All serial timing is counted in system clocks. Separate parameters set the clock-low (data setup) interval, the clock-high interval and the recovery gap that must pass before the next frame.

Top module: `serpanel_port`

## Requirements
- R1: After reset and between frames, `pnl_en` is 1, `pnl_sck` is 0, `pnl_sdo_oe` is 1 and `busy` is 0. After reset, `done` is 0 and `rdata` is 0.
- R2: A write frame (`rd_sel`=0) sends the 16-bit word {addr[7:0], wdata[7:0]} most significant bit first. Each bit is valid on `pnl_sdo` at the rising edge of `pnl_sck`.
- R3: A read frame (`rd_sel`=1) sends 8 address bits first, most significant first, with address bit 7 forced to 1 as the read marker.
- R4: In a read frame `pnl_sdo_oe` is 0 for clock rises 9 to 16 and is 1 again from the end of the frame. In a write frame it stays 1 for the whole frame.
- R5: In a read frame `pnl_sdi` is sampled in the last system cycle of each of the clock-high intervals 9 to 16. The samples are shifted in most significant bit first, and the resulting byte is placed on `rdata`.
- R6: `pnl_en` falls before the first clock rise and stays low for exactly 16 rises of `pnl_sck`. It returns high in the cycle in which the 16th high interval ends.
- R7: Before every rise, `pnl_sck` is low for exactly SETUP_CYC system cycles while the data is already stable. Each high interval lasts exactly HIGH_CYC cycles.
- R8: After `pnl_en` returns high, `busy` stays high for exactly GAP_CYC cycles. A `start` during that gap is ignored.
- R9: `done` is high for exactly one cycle when a frame ends. `rdata` changes only in that cycle and only for a read frame. A write leaves `rdata` unchanged.
- R10: A `start` while `busy` is high neither alters the frame in progress nor queues another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a frame; taken only while idle |
| rd_sel | input | 1 | 1 selects a read frame, 0 a write frame |
| addr | input | 8 | Panel register address |
| wdata | input | 8 | Value to write |
| rdata | output | 8 | Byte returned by the last read |
| busy | output | 1 | Frame or recovery gap in progress |
| done | output | 1 | One-cycle pulse at frame end |
| pnl_en | output | 1 | Active-low frame enable to the panel |
| pnl_sck | output | 1 | Serial clock, idles low |
| pnl_sdo | output | 1 | Data driven toward the panel |
| pnl_sdo_oe | output | 1 | 1 while the master drives the shared data line |
| pnl_sdi | input | 1 | Data read from the shared data line |

## Verification
Reads are issued to all 256 register addresses, and a behavioural panel answers each one with a byte computed from the address. This separates errors in the read marker, in the point where the line turns around, and in the order in which bits are collected. Writes cover 64 computed address and data pairs, plus the all-ones, all-zeros and alternating patterns. Because writes are interleaved with reads, a write that disturbs the last read result is caught. Some frames receive extra `start` pulses in the middle of the frame and in the recovery gap, which shows whether the block accepts a frame it should have refused.

// File: rtl/serpanel_port.sv
module serpanel_port #(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int SETUP_CYC = 8,
  parameter int HIGH_CYC  = 1,
  parameter int GAP_CYC   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rd_sel,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          busy,
  output logic          done,
  output logic          pnl_en,
  output logic          pnl_sck,
  output logic          pnl_sdo,
  output logic          pnl_sdo_oe,
  input  logic          pnl_sdi
);
  localparam int FW   = AW + DW;
  localparam int M1   = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC;
  localparam int MAXC = (M1 > GAP_CYC) ? M1 : GAP_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int BW   = $clog2(FW);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_GAP} phase_t;

  phase_t        ph;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [FW-1:0] sh;
  logic [DW-1:0] cap;
  logic [DW-1:0] rd_q;
  logic          is_rd;
  logic          done_q;

  wire active  = (ph == S_LOW) || (ph == S_HIGH);
  wire rx      = is_rd && (bitn >= BW'(AW));
  wire low_end = (cnt == CW'(SETUP_CYC - 1));
  wire hi_end  = (cnt == CW'(HIGH_CYC - 1));
  wire gap_end = (cnt == CW'(GAP_CYC - 1));
  wire last    = (bitn == BW'(FW - 1));

  assign pnl_en     = !active;
  assign pnl_sck    = (ph == S_HIGH);
  assign pnl_sdo_oe = !(active && rx);
  assign pnl_sdo    = active && !rx && sh[FW-1];
  assign busy       = (ph != S_IDLE);
  assign done       = done_q;
  assign rdata      = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= S_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      sh     <= '0;
      cap    <= '0;
      rd_q   <= '0;
      is_rd  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (ph)
        S_IDLE: if (start) begin
          ph    <= S_LOW;
          cnt   <= '0;
          bitn  <= '0;
          cap   <= '0;
          is_rd <= rd_sel;
          sh    <= {rd_sel | addr[AW-1], addr[AW-2:0], rd_sel ? {DW{1'b0}} : wdata};
        end
        S_LOW: begin
          if (low_end) begin
            ph  <= S_HIGH;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HIGH: begin
          if (hi_end) begin
            cnt <= '0;
            sh  <= {sh[FW-2:0], 1'b0};
            if (rx) cap <= {cap[DW-2:0], pnl_sdi};
            if (last) begin
              ph     <= S_GAP;
              done_q <= 1'b1;
              if (is_rd) rd_q <= {cap[DW-2:0], pnl_sdi};
            end else begin
              ph   <= S_LOW;
              bitn <= bitn + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (gap_end) begin
            ph  <= S_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

module serpanel_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] rdata,
  input logic          pnl_en,
  input logic          pnl_sck,
  input logic          pnl_sdo_oe
);
  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pnl_en && !pnl_sck && pnl_sdo_oe));

  p_sck_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pnl_sck |-> !pnl_en);

  p_release_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pnl_sdo_oe |-> !pnl_en);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> done);

  p_done_in_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && pnl_en));

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));
endmodule

bind serpanel_port serpanel_port_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .rdata(rdata), .pnl_en(pnl_en), .pnl_sck(pnl_sck), .pnl_sdo_oe(pnl_sdo_oe)
);

// File: tb/serpanel_port_tb.sv
module serpanel_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETUP = 8;
  localparam int HIGH  = 1;
  localparam int GAP   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, rd_sel = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic busy, done, pnl_en, pnl_sck, pnl_sdo, pnl_sdo_oe;
  logic pnl_sdi = 1'b0;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serpanel_port #(.SETUP_CYC(SETUP), .HIGH_CYC(HIGH), .GAP_CYC(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_sel(rd_sel), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(busy), .done(done), .pnl_en(pnl_en),
    .pnl_sck(pnl_sck), .pnl_sdo(pnl_sdo), .pnl_sdo_oe(pnl_sdo_oe), .pnl_sdi(pnl_sdi)
  );

  function automatic logic [7:0] reply(input logic [7:0] a);
    return (a * 8'd29 + 8'h5A) ^ {a[3:0], a[7:4]};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // panel model and line monitor
  logic [15:0] cap, last_word;
  int nrises, last_rises, lo_len, hi_len, tim_err, oe_err, frames;
  logic sck_q, en_q, cur_rd;
  logic [7:0] resp_val;

  always @(negedge clk) begin
    if (!rst_n) begin
      cap = '0; last_word = '0; nrises = 0; last_rises = 0; lo_len = 0; hi_len = 0;
      tim_err = 0; oe_err = 0; frames = 0; sck_q = 1'b0; en_q = 1'b1;
    end else begin
      if (!pnl_en) begin
        if (en_q) begin nrises = 0; lo_len = 0; hi_len = 0; cap = '0; end
        if (pnl_sck && !sck_q) begin
          if (lo_len != SETUP) tim_err++;
          lo_len = 0; hi_len = 1; nrises++;
          cap = {cap[14:0], pnl_sdo_oe ? pnl_sdo : 1'b0};
          if (nrises <= 8 && !pnl_sdo_oe) oe_err++;
          if (nrises > 8 && cur_rd && pnl_sdo_oe) oe_err++;
          if (nrises > 8 && !cur_rd && !pnl_sdo_oe) oe_err++;
        end else if (pnl_sck) begin
          hi_len++;
        end else begin
          if (sck_q) begin
            if (hi_len != HIGH) tim_err++;
            hi_len = 0;
            if (nrises >= 8 && nrises <= 15) pnl_sdi = resp_val[15 - nrises];
          end
          lo_len++;
        end
      end else if (!en_q) begin
        if (sck_q && hi_len != HIGH) tim_err++;
        if (!pnl_sdo_oe) oe_err++;
        frames++;
        last_word = cap;
        last_rises = nrises;
      end
      if (pnl_en && pnl_sck) tim_err++;
      sck_q = pnl_sck;
      en_q = pnl_en;
    end
  end

  task automatic xfer(input logic rd, input logic [7:0] a, input logic [7:0] d, input bit inject);
    int f0, t0, o0, g, n;
    logic [7:0] old_rd, exp_hi;
    bit first;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    cur_rd = rd; resp_val = reply(a);
    f0 = frames; t0 = tim_err; o0 = oe_err; old_rd = rdata;
    start = 1'b1; rd_sel = rd; addr = a; wdata = d;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      repeat (40) @(negedge clk);
      start = 1'b1; rd_sel = ~rd; addr = ~a; wdata = ~d;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    check("R9 done seen", int'(done), 1);
    if (inject) start = 1'b1;
    g = 0; first = 1;
    while (busy) begin
      g++;
      @(negedge clk);
      start = 1'b0;
      if (first) begin check("R9 done width", int'(done), 0); first = 0; end
    end
    check("R8 recovery length", g, GAP);
    repeat (3) @(negedge clk);
    check("R8/R10 no extra frame busy", int'(busy), 0);
    check("R10 frame count", frames - f0, 1);
    check("R6 rises per frame", last_rises, 16);
    check("R7 setup/high timing", tim_err - t0, 0);
    check("R4 line direction", oe_err - o0, 0);
    exp_hi = rd ? (a | 8'h80) : a;
    check(rd ? "R3 read address byte" : "R2 write address byte", int'(last_word[15:8]), int'(exp_hi));
    if (rd) check("R5 read data", int'(rdata), int'(reply(a)));
    else begin
      check("R2 write data byte", int'(last_word[7:0]), int'(d));
      check("R9 rdata kept on write", int'(rdata), int'(old_rd));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset en", int'(pnl_en), 1);
    check("R1 reset sck", int'(pnl_sck), 0);
    check("R1 reset oe", int'(pnl_sdo_oe), 1);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset done", int'(done), 0);
    check("R1 reset rdata", int'(rdata), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle en", int'(pnl_en), 1);
    xfer(1'b0, 8'hFF, 8'h00, 0);
    xfer(1'b0, 8'h00, 8'hFF, 0);
    xfer(1'b0, 8'hAA, 8'h55, 1);
    for (int i = 0; i < 256; i++) begin
      xfer(1'b1, 8'(i), 8'h00, (i % 32) == 5);
      if (i < 64) xfer(1'b0, 8'(i * 73 + 11), 8'(i * 151 + 6), (i % 16) == 3);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule